// File: doc/BRIEF.md
# Per-line video CRC checker

This block watches the two 10-bit word streams of a high-definition serial digital video link, luma and chroma, and checks the CRC that each line carries. It finds timing reference sequences on the luma stream. A start-of-active-video code opens a line. From the first active word onward, each lane runs its own 18-bit CRC over the words it sees. The run stops after the second line-number word that follows the end-of-active-video code. The two words after that hold the received CRC. The block compares them with the computed value.

A wrong CRC sets a sticky error flag for that lane only. A CRC that is absent also sets the flag. Absent means either the CRC words break their parity-style bit-9 rule, or a new line starts before the previous one sent its end code. Flags stay set until a one-cycle clear strobe. They are held low whenever the link is not in HD mode.

Words enter through a valid/ready port. `in_ready` is always high, because the block never applies back-pressure. A word is taken in each clock where `in_valid` is high. A cycle with `in_valid` low carries nothing: its data is ignored and it does not advance the line position.

Top module: `line_crc_monitor`

## Requirements
- R1: `in_ready` is high in every cycle after reset. Data presented while `in_valid` is low has no effect on flags, CRC state or line position.
- R2: A timing code is recognised on the luma lane when three accepted words of 0x3FF, 0x000 and 0x000 are followed by a fourth accepted word. Bit 6 of that fourth word selects the code type: 1 means end of active video, 0 means start of active video. A start code opens a line, and both lanes use this shared timing.
- R3: Each lane's CRC register is 18 bits wide. At the first accepted word after the start code, the register is treated as zero. For each word, bits are taken from bit 0 up to bit 9. For each bit, feedback = crc[17] XOR bit; the register shifts left by one; if feedback is 1, it is XORed with 0x00031. Every accepted word from the first active word through the second word after the end code is fed.
- R4: The two words after the second line-number word are the CRC words. The first carries crc[8:0] in bits 8:0. The second carries crc[17:9] in bits 8:0. In each, bit 9 must be the inverse of bit 8.
- R5: A mismatch between the received CRC and the computed CRC raises that lane's flag at the clock edge that takes the second CRC word. The other lane is unaffected.
- R6: If either CRC word breaks the bit-9 rule, the lane's flag is set even when bits 8:0 match.
- R7: If a start code arrives while a line is open and no end code has been seen, both flags are set. A new line then opens.
- R8: An end code with no open line (for example, the first one after reset) starts no check and sets no flag.
- R9: Flags are sticky. A one-cycle `clr_err` clears them. If a clear and a new error fall in the same cycle, the flag is set.
- R10: While `hd_mode` is low, both flags are driven low at the next edge and line tracking returns to idle. The flags reset low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word pair present on `y_word`/`c_word` |
| in_ready | output | 1 | Always high: words are never stalled |
| y_word | input | 10 | Luma lane word |
| c_word | input | 10 | Chroma lane word |
| hd_mode | input | 1 | High selects HD operation; low holds flags clear |
| clr_err | input | 1 | One-cycle strobe clearing both flags |
| y_crc_err | output | 1 | Sticky luma CRC error flag |
| c_crc_err | output | 1 | Sticky chroma CRC error flag |

## Verification
The hardest case to reach from the ports is a clear strobe that lands in exactly the cycle where the second CRC word is accepted. The check decision exists only on that edge. The bench builds each line as an indexed word array and raises `clr_err` while the word at the second-CRC index is being driven, so the two coincide on one edge. The missing-end-code case is also awkward to reach, because it needs a truncated line. The bench plays only the start code and the active words of one line and then sends a complete line.

// File: rtl/line_crc_pkg.sv
package line_crc_pkg;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_ACTIVE,
    LS_NUM0,
    LS_NUM1,
    LS_CHK0,
    LS_CHK1
  } line_pos_e;

  // Per-word controls shared by both lanes
  typedef struct packed {
    logic feed;     // word enters the CRC
    logic first;    // CRC preset to zero before this word
    logic chk0;     // first CRC word slot
    logic chk1;     // second CRC word slot
    logic missing;  // line restarted without an end code
  } lane_ctl_t;

endpackage

// File: rtl/trs_finder.sv
module trs_finder #(
  parameter int WORD_W  = 10,
  parameter int FLAG_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  output logic              is_code,
  output logic              is_end
);
  localparam logic [WORD_W-1:0] ONES  = '1;
  localparam logic [WORD_W-1:0] ZEROS = '0;

  logic [WORD_W-1:0] hist_q [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) hist_q[i] <= '0;
    end else if (take) begin
      hist_q[2] <= hist_q[1];
      hist_q[1] <= hist_q[0];
      hist_q[0] <= word;
    end
  end

  assign is_code = take && hist_q[2] == ONES && hist_q[1] == ZEROS && hist_q[0] == ZEROS;
  assign is_end  = word[FLAG_BIT];
endmodule

// File: rtl/line_tracker.sv
module line_tracker
  import line_crc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      take,
  input  logic      is_code,
  input  logic      is_end,
  output lane_ctl_t ctl
);
  line_pos_e pos_q, pos_d;
  logic      first_q, first_d;

  always_comb begin
    ctl     = '0;
    pos_d   = pos_q;
    first_d = first_q;
    if (!enable) begin
      pos_d   = LS_IDLE;
      first_d = 1'b0;
    end else if (take) begin
      unique case (pos_q)
        LS_IDLE: begin
          if (is_code && !is_end) begin
            pos_d   = LS_ACTIVE;
            first_d = 1'b1;
          end
        end
        LS_ACTIVE: begin
          if (is_code && !is_end) begin
            ctl.missing = 1'b1;
            first_d     = 1'b1;
          end else begin
            ctl.feed  = 1'b1;
            ctl.first = first_q;
            first_d   = 1'b0;
            if (is_code) pos_d = LS_NUM0;
          end
        end
        LS_NUM0: begin ctl.feed = 1'b1; pos_d = LS_NUM1; end
        LS_NUM1: begin ctl.feed = 1'b1; pos_d = LS_CHK0; end
        LS_CHK0: begin ctl.chk0 = 1'b1; pos_d = LS_CHK1; end
        LS_CHK1: begin ctl.chk1 = 1'b1; pos_d = LS_IDLE; end
        default: pos_d = LS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= LS_IDLE;
      first_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      first_q <= first_d;
    end
  end
endmodule

// File: rtl/crc_lane.sv
module crc_lane
  import line_crc_pkg::*;
#(
  parameter int              WORD_W = 10,
  parameter int              CRC_W  = 18,
  parameter logic [CRC_W-1:0] POLY  = 18'h00031
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  lane_ctl_t         ctl,
  input  logic [WORD_W-1:0] word,
  input  logic              clr,
  output logic              err
);
  localparam int HALF_W = CRC_W / 2;

  logic [CRC_W-1:0]  crc_q;
  logic [HALF_W-1:0] low_q;
  logic              low_ok_q;
  logic              word_ok;
  logic              hit;

  function automatic logic [CRC_W-1:0] advance(input logic [CRC_W-1:0] seed,
                                               input logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = seed;
    for (int i = 0; i < WORD_W; i++) begin
      fb = r[CRC_W-1] ^ w[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  assign word_ok = word[WORD_W-1] ^ word[HALF_W-1];
  assign hit = ctl.missing ||
               (ctl.chk1 && (!low_ok_q || !word_ok ||
                             {word[HALF_W-1:0], low_q} != crc_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= '0;
      low_q    <= '0;
      low_ok_q <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (ctl.feed) crc_q <= advance(ctl.first ? '0 : crc_q, word);
      if (ctl.chk0) begin
        low_q    <= word[HALF_W-1:0];
        low_ok_q <= word_ok;
      end
      if (!enable)  err <= 1'b0;
      else if (hit) err <= 1'b1;
      else if (clr) err <= 1'b0;
    end
  end
endmodule

// File: rtl/line_crc_monitor.sv
module line_crc_monitor
  import line_crc_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CRC_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] y_word,
  input  logic [WORD_W-1:0] c_word,
  input  logic              hd_mode,
  input  logic              clr_err,
  output logic              y_crc_err,
  output logic              c_crc_err
);
  localparam int LANES = 2;

  logic              is_code, is_end;
  lane_ctl_t         ctl;
  logic [WORD_W-1:0] lane_word [LANES];
  logic [LANES-1:0]  lane_err;

  assign in_ready     = 1'b1;
  assign lane_word[0] = y_word;
  assign lane_word[1] = c_word;

  trs_finder #(.WORD_W(WORD_W)) u_find (
    .clk, .rst_n, .take(in_valid), .word(y_word),
    .is_code, .is_end
  );

  line_tracker u_track (
    .clk, .rst_n, .enable(hd_mode), .take(in_valid),
    .is_code, .is_end, .ctl
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    crc_lane #(.WORD_W(WORD_W), .CRC_W(CRC_W)) u_lane (
      .clk, .rst_n, .enable(hd_mode), .ctl,
      .word(lane_word[g]), .clr(clr_err), .err(lane_err[g])
    );
  end

  assign y_crc_err = lane_err[0];
  assign c_crc_err = lane_err[1];
endmodule

// File: rtl/line_crc_monitor_sva.sv
module line_crc_monitor_sva (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic hd_mode,
  input logic clr_err,
  input logic y_crc_err,
  input logic c_crc_err
);
  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R1
  y_rise_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(y_crc_err) |-> $past(in_valid));

  // R1
  c_rise_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_crc_err) |-> $past(in_valid));

  // R9
  y_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_crc_err && !clr_err && hd_mode) |=> y_crc_err);

  // R9
  c_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_crc_err && !clr_err && hd_mode) |=> c_crc_err);

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !in_valid) |=> (!y_crc_err && !c_crc_err));

  // R10
  sd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_mode |=> (!y_crc_err && !c_crc_err));
endmodule

bind line_crc_monitor line_crc_monitor_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .hd_mode(hd_mode), .clr_err(clr_err),
  .y_crc_err(y_crc_err), .c_crc_err(c_crc_err)
);

// File: tb/line_crc_monitor_test.sv
`timescale 1ns/1ps
module line_crc_monitor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] y_word = '0;
  logic [9:0] c_word = '0;
  logic       hd_mode = 1'b1;
  logic       clr_err = 1'b0;
  logic       y_crc_err, c_crc_err;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  localparam int LEN = 22;
  logic [9:0] ly [LEN];
  logic [9:0] lc [LEN];

  always #2.5 clk = ~clk;

  line_crc_monitor uut (
    .clk, .rst_n, .in_valid, .in_ready, .y_word, .c_word,
    .hd_mode, .clr_err, .y_crc_err, .c_crc_err
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R3 reference: bits taken LSB first, MSB-out register, mask 0x31
  function automatic logic [17:0] ref_crc(input logic [17:0] c, input logic [9:0] w);
    logic [17:0] r = c;
    for (int b = 0; b < 10; b++) begin
      logic top = r[17];
      r = r << 1;
      if (top != w[b]) r = r ^ 18'h00031;
    end
    return r;
  endfunction

  task automatic build_line(input int ys, input int cs);
    logic [17:0] cy, cc;
    for (int i = 0; i < LEN; i++) begin ly[i] = 10'h040; lc[i] = 10'h040; end
    ly[0] = 10'h3FF; ly[1] = 10'h000; ly[2] = 10'h000; ly[3] = 10'h200;
    lc[0] = 10'h3FF; lc[1] = 10'h000; lc[2] = 10'h000; lc[3] = 10'h200;
    for (int i = 4; i < 12; i++) begin
      ly[i] = 10'((ys * 37 + i * 53) % 700 + 64);
      lc[i] = 10'((cs * 41 + i * 29) % 700 + 64);
    end
    ly[12] = 10'h3FF; ly[13] = 10'h000; ly[14] = 10'h000; ly[15] = 10'h274;
    lc[12] = 10'h3FF; lc[13] = 10'h000; lc[14] = 10'h000; lc[15] = 10'h274;
    ly[16] = 10'h22C; ly[17] = 10'h200; lc[16] = 10'h22C; lc[17] = 10'h200;
    cy = '0; cc = '0;
    for (int i = 4; i < 18; i++) begin
      cy = ref_crc(cy, ly[i]);
      cc = ref_crc(cc, lc[i]);
    end
    ly[18] = {~cy[8], cy[8:0]};  ly[19] = {~cy[17], cy[17:9]};
    lc[18] = {~cc[8], cc[8:0]};  lc[19] = {~cc[17], cc[17:9]};
  endtask

  // Plays words lo..hi; clears with word clr_at; gap inserts idle garbage cycles
  task automatic play(input int lo, input int hi, input int clr_at, input bit gap);
    for (int i = lo; i <= hi; i++) begin
      @(negedge clk);
      in_valid = 1'b1; y_word = ly[i]; c_word = lc[i]; clr_err = (i == clr_at);
      if (gap) begin
        @(negedge clk);
        in_valid = 1'b0; clr_err = 1'b0; y_word = 10'h3FF; c_word = 10'h000;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; clr_err = 1'b0; y_word = '0; c_word = '0;
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    check(y_crc_err == 1'b0, "R10 y reset", y_crc_err, 0);
    check(c_crc_err == 1'b0, "R10 c reset", c_crc_err, 0);
  endtask

  task automatic t_orphan_end();
    build_line(1, 2);
    play(12, 21, -1, 0);
    check({y_crc_err, c_crc_err} == 2'b00, "R8 orphan end code", {y_crc_err, c_crc_err}, 0);
  endtask

  task automatic t_clean();
    build_line(3, 4);
    play(0, 21, -1, 0);
    check({y_crc_err, c_crc_err} == 2'b00, "R3 R4 clean line", {y_crc_err, c_crc_err}, 0);
    build_line(9, 5);
    play(0, 21, -1, 0);
    check({y_crc_err, c_crc_err} == 2'b00, "R2 second clean line", {y_crc_err, c_crc_err}, 0);
  endtask

  task automatic t_gaps();
    build_line(6, 7);
    play(0, 21, -1, 1);
    check({y_crc_err, c_crc_err} == 2'b00, "R1 idle cycles ignored", {y_crc_err, c_crc_err}, 0);
  endtask

  task automatic t_y_only();
    build_line(2, 8);
    ly[7] = ly[7] ^ 10'h010;
    play(0, 21, -1, 0);
    check(y_crc_err == 1'b1, "R5 y mismatch", y_crc_err, 1);
    check(c_crc_err == 1'b0, "R5 c untouched", c_crc_err, 0);
    build_line(4, 4);
    play(0, 21, -1, 0);
    check(y_crc_err == 1'b1, "R9 y sticky", y_crc_err, 1);
    do_clear();
    check(y_crc_err == 1'b0, "R9 y cleared", y_crc_err, 0);
  endtask

  task automatic t_c_only();
    build_line(5, 1);
    lc[16] = lc[16] ^ 10'h001;
    play(0, 21, -1, 0);
    check(c_crc_err == 1'b1, "R5 c mismatch in line number", c_crc_err, 1);
    check(y_crc_err == 1'b0, "R5 y untouched", y_crc_err, 0);
    do_clear();
  endtask

  task automatic t_parity();
    build_line(8, 3);
    ly[18] = ly[18] ^ 10'h200;
    play(0, 21, -1, 0);
    check(y_crc_err == 1'b1, "R6 bad bit9 first word", y_crc_err, 1);
    check(c_crc_err == 1'b0, "R6 c untouched", c_crc_err, 0);
    do_clear();
    build_line(8, 3);
    lc[19] = lc[19] ^ 10'h200;
    play(0, 21, -1, 0);
    check(c_crc_err == 1'b1, "R6 bad bit9 second word", c_crc_err, 1);
    do_clear();
  endtask

  task automatic t_clear_race();
    build_line(7, 2);
    ly[5] = ly[5] ^ 10'h100;
    play(0, 21, 19, 0);
    check(y_crc_err == 1'b1, "R9 set beats clear", y_crc_err, 1);
    do_clear();
  endtask

  task automatic t_missing_end();
    build_line(3, 9);
    play(0, 11, -1, 0);
    check({y_crc_err, c_crc_err} == 2'b00, "R7 open line no flag yet", {y_crc_err, c_crc_err}, 0);
    play(0, 21, -1, 0);
    check({y_crc_err, c_crc_err} == 2'b11, "R7 missing end code", {y_crc_err, c_crc_err}, 3);
    do_clear();
    build_line(1, 1);
    play(0, 21, -1, 0);
    check({y_crc_err, c_crc_err} == 2'b00, "R7 recovers after clear", {y_crc_err, c_crc_err}, 0);
  endtask

  task automatic t_sd();
    build_line(2, 2);
    ly[6] = ly[6] ^ 10'h002;
    play(0, 21, -1, 0);
    check(y_crc_err == 1'b1, "R10 error before mode drop", y_crc_err, 1);
    @(negedge clk); hd_mode = 1'b0;
    @(negedge clk);
    check(y_crc_err == 1'b0, "R10 flag dropped in SD", y_crc_err, 0);
    build_line(2, 2);
    ly[6] = ly[6] ^ 10'h002; lc[6] = lc[6] ^ 10'h002;
    play(0, 21, -1, 0);
    check({y_crc_err, c_crc_err} == 2'b00, "R10 SD ignores errors", {y_crc_err, c_crc_err}, 0);
    @(negedge clk); hd_mode = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_orphan_end();
    t_clean();
    t_gaps();
    t_y_only();
    t_c_only();
    t_parity();
    t_clear_race();
    t_missing_end();
    t_sd();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule